// File: doc/BRIEF.md
# Configurable Serial Transmitter with Line Break

This block turns bytes into an asynchronous serial stream on one output line. A 30-bit setup word selects the bit period in system clocks, the number of data bits (five to eight), one or two stop bits, and the parity mode. The parity mode can be odd, even, or a fixed parity bit that is always 0 or always 1. A producer presents a byte with a write strobe. The byte is taken on the first clock where the block reports that it is not busy. The producer holds the strobe until then and drops it afterwards.

A separate break request pulls the line low for as long as the request is held, and it cuts short any character in flight. When the request drops, the line goes high for one full bit period before the block accepts a new byte. The setup word is sampled only while the transmitter is idle or in break. A setup change made during a character therefore first affects the next one.

Top module: `sertx_core`

## Requirements
- R1: After reset the line is high and busy is low. Whenever busy is low, the line is high.
- R2: A byte is accepted only on a clock where `wr_stb` is high, busy is low and `brk_req` is low. A strobe seen while busy is ignored and produces no extra frame.
- R3: From the clock after acceptance, the frame is sent in this order: a 0 start bit, then the data bits least significant first, then the optional parity bit, then the stop bits at 1. Each bit lasts exactly `cfg_word[23:0]` clocks, and a value of 0 is treated as 1.
- R4: `cfg_word[29:28]` sets the data bit count: 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. Only the low bits of the byte are sent.
- R5: `cfg_word[26]`=1 adds a parity bit, computed over the sent data bits only. With `cfg_word[25]`=0, `cfg_word[24]`=0 selects odd parity and 1 selects even parity. With `cfg_word[25]`=1, the parity bit equals `cfg_word[24]`.
- R6: `cfg_word[27]`=1 sends two stop bits and 0 sends one.
- R7: Busy stays high for exactly (frame bits × bit period) clocks after acceptance, then drops. A new byte can be accepted on the first idle clock.
- R8: Changes to `cfg_word` while a character is being sent do not alter that character.
- R9: From the clock after `brk_req` is seen high, the line is low and busy is high. This holds for as long as the request stays high and aborts any character in flight. A strobe during break, or in the same clock that break starts, is discarded.
- R10: After `brk_req` falls, the line is high and busy stays high for exactly one bit period. After that the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 30 | Setup word: [29:28] length code, [27] two stops, [26] parity on, [25] fixed parity, [24] parity select, [23:0] clocks per bit |
| brk_req | input | 1 | Hold high to drive a break |
| wr_stb | input | 1 | Byte request strobe |
| wr_byte | input | 8 | Byte to send |
| line_out | output | 1 | Serial line |
| busy | output | 1 | High while a character, break or post-break recovery is in progress |

## Verification
The bench compares the line on every clock of every frame against a bit sequence it builds itself. This catches an off-by-one bit period, a wrong bit order, or a frame that ends one bit early or late. It targets parity over five-bit words with stray upper bits set: a design that folds those bits into the parity gets the parity bit wrong. It also changes the setup word and pulses the strobe in the middle of frames, so a design that samples the setup live or queues a second byte produces corrupted bits or an extra frame. Break is applied in the middle of a character and in the same clock as a strobe, and the recovery time is measured to the clock. A design that skips the high recovery period, or resumes the aborted character, is caught.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int BAUD_W    = 24;
  localparam int DATA_MAX  = 8;
  localparam int FRAME_MAX = DATA_MAX + 4;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic [1:0]        wlen_code;
    logic              two_stop;
    logic              par_en;
    logic              par_fixed;
    logic              par_sel;
    logic [BAUD_W-1:0] baud;
  } sertx_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_BRK, ST_GUARD} sertx_state_t;

  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'd8 - {2'b00, code};
  endfunction

  function automatic logic [LEN_W-1:0] frame_bits(input sertx_cfg_t c);
    return LEN_W'(2) + LEN_W'(data_bits(c.wlen_code)) + LEN_W'(c.par_en) + LEN_W'(c.two_stop);
  endfunction

  function automatic logic parity_bit(input sertx_cfg_t c, input logic [DATA_MAX-1:0] d);
    logic [DATA_MAX-1:0] mask;
    logic                x;
    mask = {DATA_MAX{1'b1}} >> c.wlen_code;
    x    = ^(d & mask);
    if (c.par_fixed) return c.par_sel;
    return c.par_sel ? x : ~x;
  endfunction

  function automatic logic [BAUD_W-1:0] baud_m1(input sertx_cfg_t c);
    return (c.baud == '0) ? '0 : c.baud - 1'b1;
  endfunction
endpackage

// File: rtl/sertx_baud_timer.sv
module sertx_baud_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/sertx_frame_pack.sv
module sertx_frame_pack
  import sertx_pkg::*;
(
  input  sertx_cfg_t                  cfg,
  input  logic [DATA_MAX-1:0]         data,
  output logic [FRAME_MAX-1:0]        frame,
  output logic [LEN_W-1:0]            nbits
);
  logic [3:0] nd;

  always_comb begin
    nd       = data_bits(cfg.wlen_code);
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < int'(nd)) frame[i+1] = data[i];
    end
    if (cfg.par_en) frame[int'(nd) + 1] = parity_bit(cfg, data);
    nbits = frame_bits(cfg);
  end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [29:0] cfg_word,
  input  logic        brk_req,
  input  logic        wr_stb,
  input  logic [7:0]  wr_byte,
  output logic        line_out,
  output logic        busy
);
  sertx_state_t           state;
  sertx_cfg_t             act_cfg;
  sertx_cfg_t             cfg_in;
  logic [FRAME_MAX-1:0]   shreg;
  logic [FRAME_MAX-1:0]   frame;
  logic [LEN_W-1:0]       nbits;
  logic [LEN_W-1:0]       bits_left;
  logic                   tick;

  // named internal events
  logic accept, bit_edge, last_bit, brk_exit, tmr_load;
  logic [BAUD_W-1:0] tmr_val;

  assign cfg_in   = sertx_cfg_t'(cfg_word);
  assign accept   = (state == ST_IDLE) && wr_stb && !brk_req;
  assign bit_edge = (state == ST_SEND) && tick;
  assign last_bit = bit_edge && (bits_left == '0);
  assign brk_exit = (state == ST_BRK) && !brk_req;
  assign tmr_load = accept || (bit_edge && !last_bit) || brk_exit;
  assign tmr_val  = accept ? baud_m1(cfg_in) : baud_m1(act_cfg);

  sertx_frame_pack u_pack (
    .cfg   (cfg_in),
    .data  (wr_byte),
    .frame (frame),
    .nbits (nbits)
  );

  sertx_baud_timer #(.W(BAUD_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      act_cfg   <= '0;
      shreg     <= '1;
      bits_left <= '0;
    end else begin
      if (state == ST_IDLE || state == ST_BRK) act_cfg <= cfg_in;
      if (brk_req) begin
        state <= ST_BRK;
      end else begin
        unique case (state)
          ST_IDLE: if (wr_stb) begin
            state     <= ST_SEND;
            shreg     <= frame;
            bits_left <= nbits - LEN_W'(1);
          end
          ST_SEND: if (bit_edge) begin
            if (bits_left == '0) state <= ST_IDLE;
            else begin
              shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
              bits_left <= bits_left - LEN_W'(1);
            end
          end
          ST_BRK:   state <= ST_GUARD;
          ST_GUARD: if (tick) state <= ST_IDLE;
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_SEND: line_out = shreg[0];
      ST_BRK:  line_out = 1'b0;
      default: line_out = 1'b1;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // assertions
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line_out);
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !busy && !brk_req) |=> (busy && !line_out));
  a_r3_bit_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && $past(state) == ST_SEND && !$past(bit_edge)) |-> $stable(line_out));
  a_r7_frame_end: assert property (@(posedge clk) disable iff (rst)
    (last_bit && !brk_req) |=> !busy);
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && $past(state) == ST_SEND) |-> $stable(act_cfg));
  a_r9_break_low: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> (!line_out && busy));
  a_r10_guard_high: assert property (@(posedge clk) disable iff (rst)
    brk_exit |=> (line_out && busy));
endmodule

// File: tb/sertx_core_tb.sv
`timescale 1ns/1ps
module sertx_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [29:0] cfg_word = '0;
  logic        brk_req = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic        line_out, busy;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sertx_core u_dut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .brk_req(brk_req),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .line_out(line_out), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int b_clks(input logic [29:0] c);
    return (c[23:0] == 24'd0) ? 1 : int'(c[23:0]);
  endfunction
  function automatic int b_nd(input logic [29:0] c);
    return 8 - int'(c[29:28]);
  endfunction
  function automatic int b_len(input logic [29:0] c);
    return 2 + b_nd(c) + int'(c[26]) + int'(c[27]);
  endfunction
  function automatic logic b_bit(input logic [29:0] c, input logic [7:0] d, input int j);
    int nd, ones;
    nd = b_nd(c);
    if (j == 0) return 1'b0;
    if (j <= nd) return d[j-1];
    if (c[26] && j == nd + 1) begin
      ones = 0;
      for (int i = 0; i < nd; i++) ones += int'(d[i]);
      if (c[25]) return c[24];
      return c[24] ? (ones % 2 == 1) : (ones % 2 == 0);
    end
    return 1'b1;
  endfunction

  // caller is at a negedge with the block idle
  task automatic xmit(input logic [29:0] cfg, input logic [7:0] d, input string req, input bit disturb);
    int ck, n, errs, bad_k;
    logic got, want, bad_got, bad_want;
    ck = b_clks(cfg); n = b_len(cfg) * ck; errs = 0; bad_k = 0; bad_got = 0; bad_want = 0;
    check(busy == 1'b0, "R7", "busy before send", int'(busy), 0);
    cfg_word = cfg; wr_byte = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; wr_byte = ~d;
    for (int k = 0; k < n; k++) begin
      want = b_bit(cfg, d, k / ck);
      got  = line_out;
      if (got !== want || busy !== 1'b1) begin
        if (errs == 0) begin bad_k = k; bad_got = got; bad_want = want; end
        errs++;
      end
      if (disturb && k == 2) cfg_word = 30'($urandom);
      if (disturb && k == 3) begin wr_stb = 1'b1; wr_byte = 8'($urandom); end
      if (disturb && k == 4) wr_stb = 1'b0;
      @(negedge clk);
    end
    check(errs == 0, req, $sformatf("frame line at cycle %0d (errors %0d)", bad_k, errs),
          int'(bad_got), int'(bad_want));
    check(busy == 1'b0 && line_out == 1'b1, "R7", "idle right after frame", int'(busy), 0);
    if (disturb) begin
      errs = 0;
      for (int k = 0; k < 2 * ck + 2; k++) begin
        if (busy !== 1'b0 || line_out !== 1'b1) errs++;
        @(negedge clk);
      end
      check(errs == 0, "R2", "strobe while busy made extra activity", errs, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int errs;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(line_out == 1'b1, "R1", "line in reset", int'(line_out), 1);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    check(line_out == 1'b1 && busy == 1'b0, "R1", "idle after reset", int'(line_out), 1);

    // directed frames
    xmit(30'd3, 8'h35, "R3", 1'b0);
    xmit(30'd0, 8'hC9, "R3 zero period", 1'b0);
    xmit({2'd1, 4'b0000, 24'd2}, 8'hB6, "R4 seven bits", 1'b0);
    xmit({2'd2, 4'b0000, 24'd2}, 8'hB6, "R4 six bits", 1'b0);
    xmit({2'd3, 4'b0000, 24'd2}, 8'hB6, "R4 five bits", 1'b0);
    xmit({2'd0, 1'b0, 3'b100, 24'd2}, 8'h07, "R5 odd", 1'b0);
    xmit({2'd0, 1'b0, 3'b101, 24'd2}, 8'h07, "R5 even", 1'b0);
    xmit({2'd0, 1'b0, 3'b110, 24'd2}, 8'hFF, "R5 space", 1'b0);
    xmit({2'd0, 1'b0, 3'b111, 24'd2}, 8'h00, "R5 mark", 1'b0);
    xmit({2'd3, 1'b0, 3'b101, 24'd1}, 8'hF1, "R5 masked even", 1'b0);
    xmit({2'd3, 1'b0, 3'b100, 24'd1}, 8'hE1, "R5 masked odd", 1'b0);
    xmit({2'd0, 1'b1, 3'b000, 24'd3}, 8'h5A, "R6 two stops", 1'b0);
    xmit({2'd1, 1'b1, 3'b101, 24'd2}, 8'h3C, "R8 setup change mid frame", 1'b1);

    // break in the middle of a character
    cfg_word = 30'd4; wr_byte = 8'hFF; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    repeat (6) @(negedge clk);
    brk_req = 1'b1;
    @(negedge clk);
    check(line_out == 1'b0 && busy == 1'b1, "R9", "break takes line low", int'(line_out), 0);
    errs = 0;
    for (int k = 0; k < 15; k++) begin
      if (k == 5) begin wr_stb = 1'b1; wr_byte = 8'h00; end
      if (k == 6) wr_stb = 1'b0;
      @(negedge clk);
      if (line_out !== 1'b0 || busy !== 1'b1) errs++;
    end
    check(errs == 0, "R9", "line held low during break", errs, 0);
    brk_req = 1'b0;
    errs = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (line_out !== 1'b1 || busy !== 1'b1) errs++;
    end
    check(errs == 0, "R10", "recovery high for one bit period", errs, 0);
    @(negedge clk);
    check(busy == 1'b0, "R10", "idle after recovery", int'(busy), 0);
    errs = 0;
    for (int k = 0; k < 10; k++) begin
      if (line_out !== 1'b1 || busy !== 1'b0) errs++;
      @(negedge clk);
    end
    check(errs == 0, "R9", "no resumed or queued character", errs, 0);

    // break and strobe together from idle, zero period field
    cfg_word = 30'd0; brk_req = 1'b1; wr_stb = 1'b1; wr_byte = 8'h00;
    @(negedge clk);
    wr_stb = 1'b0;
    check(line_out == 1'b0 && busy == 1'b1, "R9", "break wins over strobe", int'(line_out), 0);
    brk_req = 1'b0;
    @(negedge clk);
    check(line_out == 1'b1 && busy == 1'b1, "R10", "single-clock recovery", int'(busy), 1);
    @(negedge clk);
    errs = 0;
    for (int k = 0; k < 20; k++) begin
      if (line_out !== 1'b1 || busy !== 1'b0) errs++;
      @(negedge clk);
    end
    check(errs == 0, "R9", "strobe with break discarded", errs, 0);

    // constrained random frames
    for (int t = 0; t < 40; t++) begin
      logic [29:0] c;
      c = {2'($urandom), 4'($urandom), 24'($urandom % 6)};
      xmit(c, 8'($urandom), "R3 random", 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule